// File: doc/BRIEF.md
# Configuration Access Sequencer

This block takes one configuration-space request at a time and turns it into accesses on a 32-bit downstream request/acknowledge port. Each request carries these fields:

- a bus number
- a device/function number
- a register offset
- an access size
- a direction
- write data

The block checks the offset against the limit of the addressed function and builds the flat configuration address from the bus, device/function and offset fields. It then runs one of two access flows.

A normal access first adjusts a side-band control bit with a read-modify-write. It then performs the single requested access, with byte enables and little-endian byte lanes.

Some reads target registers that need a recovery sequence. These are reads of certain register ranges inside root-port functions. For them the block does not touch the side-band register. It runs a fixed three-step sequence and extracts the requested bytes from the full word. The result comes back with a one-cycle done pulse, read data and a status code.

Top module: `cfg_access_seq`

## Requirements
- R1: The configuration address on `m_addr` is (bus << 20) | (devfn << 12) | offset, with `m_ctl` low.
- R2: On bus 0, devfn 0, offsets below 8192 are accepted. For every other bus/devfn the limit is 4096. A request over the limit completes with status 1 (bad register) in the cycle after acceptance and makes no downstream request.
- R3: When `enable` is low, a request completes with status 2 (no device) in the cycle after acceptance and makes no downstream request. Status 0 means success.
- R4: A function is a root port when the bus is 0, devfn[2:0] < 4 and devfn[7:3] is 16 or 17. Only reads of a root port at offsets 0x18..0x33 or 0x158..0x177 take the recovery path. Writes, other offsets and other functions take the normal path.
- R5: The recovery path issues exactly three accesses, all with byte enables 4'hF and none to the side-band register. In order they are:
  - a write of zero to offset 0x10 of the same function;
  - a read of the dword at offset & ~3;
  - a write of the value just read back to that same address.
- R6: Recovery read data depends on `req_size`, with k = offset & 3:
  - size 1 returns byte k of the dword;
  - size 2 returns the low half when k is 0 and the high half otherwise;
  - size 4 returns the whole dword.
- R7: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. The normal path's access uses byte enables 4'b0001 << k for size 1, 4'b0011 << k for size 2 and 4'hF for size 4. Write data is shifted left by 8*k. Read data is returned right-aligned, with the unused upper bits zero.
- R8: Before each normal access the block reads the side-band register and writes it back:
  - both accesses have `m_ctl` high, address 4 and byte enables 4'hF;
  - the value written back is the read value with bit 11 (0x800) set when the target bus is 5, and cleared otherwise.
- R9: `req_ready` is high only when the block is idle. A request is accepted on a clock edge with `req_valid` and `req_ready` both high. `done` is a single-cycle pulse, after which the block is ready again.
- R10: `m_req` and all access fields stay stable until `m_ack`, and the next access of a sequence starts only after that acknowledge. A write returns `rdata` 0.
- R11: A synchronous active-high `rst` returns the block to idle, with `req_ready` high and `done` and `m_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller present; low gives no-device status |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 8 | Device (7:3) and function (2:0) |
| req_off | input | OFF_W | Register offset |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-aligned |
| done | output | 1 | Completion pulse |
| status | output | 2 | 0 success, 1 bad register, 2 no device |
| rdata | output | 32 | Read data, right-aligned |
| m_req | output | 1 | Downstream access request |
| m_ack | input | 1 | Downstream acknowledge |
| m_ctl | output | 1 | Access targets the side-band control space |
| m_we | output | 1 | Downstream write |
| m_addr | output | 28 | Downstream address |
| m_be | output | 4 | Byte enables |
| m_wdata | output | 32 | Downstream write data |
| m_rdata | input | 32 | Downstream read data, valid with m_ack |

## Verification
Rejected requests must raise `done` on the first sampled cycle after acceptance. The bench checks that exact latency, and also checks that no new entry appears in its access log.

The bench's memory model acknowledges each access one cycle after it sees the request. A full sequence therefore completes seven cycles after acceptance on both the normal and the recovery path. The bench measures that latency directly, counting sampled cycles until `done` rises.

Results, the ordered access log and the side-band register are compared against values that the bench computes from the address formula and the lane rules. All sampling happens on the falling edge.

// File: rtl/cfg_access_seq.sv
module cfg_access_seq #(
  parameter int          OFF_W     = 16,
  parameter int          LIM_WIDE  = 8192,
  parameter int          LIM_STD   = 4096,
  parameter int          SB_BUS    = 5,
  parameter logic [31:0] SB_MASK   = 32'h0000_0800,
  parameter int          SB_OFF    = 4,
  parameter int          DUMMY_OFF = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_bus,
  input  logic [7:0]       req_devfn,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_size,
  input  logic             req_write,
  input  logic [31:0]      req_wdata,
  output logic             done,
  output logic [1:0]       status,
  output logic [31:0]      rdata,
  output logic             m_req,
  input  logic             m_ack,
  output logic             m_ctl,
  output logic             m_we,
  output logic [27:0]      m_addr,
  output logic [3:0]       m_be,
  output logic [31:0]      m_wdata,
  input  logic [31:0]      m_rdata
);
  localparam int AW = 28;

  typedef enum logic [2:0] {S_IDLE, S_CRD, S_CWR, S_ACC, S_DMY, S_WRD, S_WWB, S_FIN} st_t;
  st_t st;

  logic [7:0]       r_bus, r_devfn;
  logic [OFF_W-1:0] r_off;
  logic [1:0]       r_size;
  logic             r_we;
  logic [31:0]      r_wdata, word;

  wire accept = req_valid && req_ready;
  wire off_ok = (req_bus == 8'd0 && req_devfn == 8'd0) ? (32'(req_off) < LIM_WIDE)
                                                        : (32'(req_off) < LIM_STD);
  wire root   = req_bus == 8'd0 && req_devfn[2:0] < 3'd4 &&
                (req_devfn[7:3] == 5'd16 || req_devfn[7:3] == 5'd17);
  wire in_rng = (32'(req_off) >= 32'h18  && 32'(req_off) < 32'h34) ||
                (32'(req_off) >= 32'h158 && 32'(req_off) < 32'h178);

  wire [AW-1:0] base   = {r_bus, 20'b0} | {8'b0, r_devfn, 12'b0};
  wire [AW-1:0] off_a  = AW'(r_off);
  wire [AW-1:0] word_a = base | {off_a[AW-1:2], 2'b00};

  logic [3:0] be_n;
  always_comb
    case (r_size)
      2'd0:    be_n = 4'b0001 << r_off[1:0];
      2'd1:    be_n = 4'b0011 << r_off[1:0];
      default: be_n = 4'b1111;
    endcase

  function automatic logic [31:0] pick(input logic [31:0] w, input logic [1:0] k,
                                       input logic [1:0] sz);
    logic [31:0] sh;
    sh = w >> {k, 3'b000};
    case (sz)
      2'd0:    return {24'b0, sh[7:0]};
      2'd1:    return (k == 2'd0) ? {16'b0, w[15:0]} : {16'b0, w[31:16]};
      default: return w;
    endcase
  endfunction

  assign req_ready = st == S_IDLE;
  assign done      = st == S_FIN;
  assign m_req     = st inside {S_CRD, S_CWR, S_ACC, S_DMY, S_WRD, S_WWB};

  always_comb begin
    m_ctl   = 1'b0;
    m_we    = 1'b0;
    m_addr  = '0;
    m_be    = 4'hF;
    m_wdata = '0;
    case (st)
      S_CRD: begin
        m_ctl  = 1'b1;
        m_addr = AW'(SB_OFF);
      end
      S_CWR: begin
        m_ctl   = 1'b1;
        m_we    = 1'b1;
        m_addr  = AW'(SB_OFF);
        m_wdata = (r_bus == 8'(SB_BUS)) ? (word | SB_MASK) : (word & ~SB_MASK);
      end
      S_ACC: begin
        m_we    = r_we;
        m_addr  = base | off_a;
        m_be    = be_n;
        m_wdata = r_wdata << {r_off[1:0], 3'b000};
      end
      S_DMY: begin
        m_we   = 1'b1;
        m_addr = base | AW'(DUMMY_OFF);
      end
      S_WRD: m_addr = word_a;
      S_WWB: begin
        m_we    = 1'b1;
        m_addr  = word_a;
        m_wdata = word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk)
    if (rst) begin
      st      <= S_IDLE;
      status  <= 2'd0;
      rdata   <= '0;
      word    <= '0;
      r_bus   <= '0;
      r_devfn <= '0;
      r_off   <= '0;
      r_size  <= '0;
      r_we    <= 1'b0;
      r_wdata <= '0;
    end else
      case (st)
        S_IDLE:
          if (accept) begin
            r_bus   <= req_bus;
            r_devfn <= req_devfn;
            r_off   <= req_off;
            r_size  <= req_size;
            r_we    <= req_write;
            r_wdata <= req_wdata;
            rdata   <= '0;
            status  <= 2'd0;
            if (!enable) begin
              status <= 2'd2;
              st     <= S_FIN;
            end else if (!off_ok) begin
              status <= 2'd1;
              st     <= S_FIN;
            end else if (!req_write && root && in_rng) st <= S_DMY;
            else st <= S_CRD;
          end
        S_CRD: if (m_ack) begin word <= m_rdata; st <= S_CWR; end
        S_CWR: if (m_ack) st <= S_ACC;
        S_ACC: if (m_ack) begin
          if (!r_we) rdata <= pick(m_rdata, r_off[1:0], r_size);
          st <= S_FIN;
        end
        S_DMY: if (m_ack) st <= S_WRD;
        S_WRD: if (m_ack) begin word <= m_rdata; st <= S_WWB; end
        S_WWB: if (m_ack) begin rdata <= pick(word, r_off[1:0], r_size); st <= S_FIN; end
        default: st <= S_IDLE;
      endcase
endmodule

// File: rtl/cfg_access_seq_chk.sv
module cfg_access_seq_chk #(parameter int OFF_W = 16) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             req_valid,
  input logic             req_ready,
  input logic [7:0]       req_bus,
  input logic [7:0]       req_devfn,
  input logic [OFF_W-1:0] req_off,
  input logic             done,
  input logic [1:0]       status,
  input logic             m_req,
  input logic             m_ack,
  input logic             m_ctl,
  input logic             m_we,
  input logic [27:0]      m_addr,
  input logic [3:0]       m_be
);
  wire acc = req_valid && req_ready;
  wire bad = 32'(req_off) >= ((req_bus == 8'd0 && req_devfn == 8'd0) ? 32'd8192 : 32'd4096);

  AST_BAD_OFFSET: assert property (@(posedge clk) disable iff (rst)
    acc && enable && bad |=> done && status == 2'd1 && !m_req);  // R2
  AST_NO_DEVICE: assert property (@(posedge clk) disable iff (rst)
    acc && !enable |=> done && status == 2'd2 && !m_req);  // R3
  AST_CTL_SHAPE: assert property (@(posedge clk) disable iff (rst)
    m_req && m_ctl |-> m_addr == 28'd4 && m_be == 4'hF);  // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && req_ready);  // R9
  AST_BUSY_ACCESS: assert property (@(posedge clk) disable iff (rst)
    m_req |-> !req_ready && !done);  // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    m_req && !m_ack |=> m_req && $stable(m_addr) && $stable(m_we) && $stable(m_be) && $stable(m_ctl));  // R10
endmodule

bind cfg_access_seq cfg_access_seq_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .req_valid(req_valid), .req_ready(req_ready),
  .req_bus(req_bus), .req_devfn(req_devfn), .req_off(req_off), .done(done),
  .status(status), .m_req(m_req), .m_ack(m_ack), .m_ctl(m_ctl), .m_we(m_we),
  .m_addr(m_addr), .m_be(m_be));

// File: tb/test_cfg_access_seq.sv
module test_cfg_access_seq;
  logic        clk = 1'b0, rst = 1'b1, enable = 1'b1;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [7:0]  req_bus = '0, req_devfn = '0;
  logic [15:0] req_off = '0;
  logic [1:0]  req_size = '0, status;
  logic [31:0] req_wdata = '0, rdata, m_wdata, m_rdata;
  logic        done, m_req, m_ack, m_ctl, m_we;
  logic [27:0] m_addr;
  logic [3:0]  m_be;

  always #10 clk = ~clk;

  cfg_access_seq i_cfg_access_seq (.*);

  int          n_tests = 0, n_fail = 0, cyc = 0;
  logic [31:0] mem [logic [25:0]];
  logic [31:0] ctl_reg;
  logic        lg_we [256], lg_ctl [256];
  logic [27:0] lg_addr [256];
  logic [3:0]  lg_be [256];
  logic [31:0] lg_wd [256];
  int          lg_n;

  always @(posedge clk) begin
    if (rst) begin
      m_ack   <= 1'b0;
      m_rdata <= '0;
      lg_n    <= 0;
      ctl_reg <= 32'hFFFF_FFFF;
    end else begin
      m_ack <= 1'b0;
      if (m_req && !m_ack) begin
        logic [31:0] cur;
        m_ack <= 1'b1;
        lg_we[lg_n & 255] <= m_we;  lg_ctl[lg_n & 255] <= m_ctl;
        lg_addr[lg_n & 255] <= m_addr; lg_be[lg_n & 255] <= m_be;
        lg_wd[lg_n & 255] <= m_wdata;
        lg_n <= lg_n + 1;
        if (m_ctl) begin
          m_rdata <= ctl_reg;
          if (m_we) ctl_reg <= m_wdata;
        end else begin
          cur = mem.exists(m_addr[27:2]) ? mem[m_addr[27:2]] : 32'h0;
          m_rdata <= cur;
          if (m_we) begin
            for (int i = 0; i < 4; i++) if (m_be[i]) cur[8*i +: 8] = m_wdata[8*i +: 8];
            mem[m_addr[27:2]] = cur;
          end
        end
      end
    end
  end

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] ca(logic [7:0] b, logic [7:0] df, logic [15:0] o);
    return {b, 20'b0} | {8'b0, df, 12'b0} | 28'(o);
  endfunction

  int lat, base_n;
  task automatic run(logic wr, logic [7:0] b, logic [7:0] df, logic [15:0] o,
                     logic [1:0] sz, logic [31:0] wd);
    base_n = lg_n;
    req_write = wr; req_bus = b; req_devfn = df; req_off = o; req_size = sz;
    req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
  endtask

  task automatic t_reset;
    chk("R11 ready after reset", 32'(req_ready), 1);
    chk("R11 done low after reset", 32'(done), 0);
    chk("R11 no access after reset", 32'(m_req), 0);
  endtask

  task automatic t_normal;
    run(1'b1, 8'd3, 8'h21, 16'h40, 2'd2, 32'hCAFE_0123);
    chk("R9 normal latency", 32'(lat), 7);
    chk("R3 success status", 32'(status), 0);
    chk("R10 write returns zero", rdata, 0);
    @(negedge clk);
    chk("R9 done single pulse", 32'(done), 0);
    chk("R8 three accesses", 32'(lg_n - base_n), 3);
    chk("R8 ctl read first", {30'b0, lg_ctl[base_n], lg_we[base_n]}, 32'b10);
    chk("R8 ctl addr", 32'(lg_addr[base_n]), 4);
    chk("R8 ctl bit cleared off bus 5", lg_wd[base_n + 1], 32'hFFFF_F7FF);
    chk("R1 address", 32'(lg_addr[base_n + 2]), 32'(ca(8'd3, 8'h21, 16'h40)));
    chk("R7 full be", 32'(lg_be[base_n + 2]), 32'hF);
    chk("R7 write data", lg_wd[base_n + 2], 32'hCAFE_0123);
    run(1'b0, 8'd3, 8'h21, 16'h40, 2'd2, 0);
    chk("R7 dword read back", rdata, 32'hCAFE_0123);
    @(negedge clk);
  endtask

  task automatic t_bus5;
    run(1'b1, 8'd5, 8'h08, 16'h100, 2'd2, 32'h1122_3344); @(negedge clk);
    chk("R8 ctl bit set for bus 5", ctl_reg, 32'hFFFF_FFFF);
    run(1'b1, 8'd5, 8'h08, 16'h103, 2'd0, 32'h0000_00AB); @(negedge clk);
    chk("R7 byte be", 32'(lg_be[base_n + 2]), 32'h8);
    chk("R7 byte lane", lg_wd[base_n + 2], 32'hAB00_0000);
    run(1'b0, 8'd5, 8'h08, 16'h102, 2'd1, 0); @(negedge clk);
    chk("R7 half be", 32'(lg_be[base_n + 2]), 32'hC);
    chk("R7 half read", rdata, 32'h0000_AB22);
    run(1'b0, 8'd5, 8'h08, 16'h101, 2'd0, 0); @(negedge clk);
    chk("R7 byte read", rdata, 32'h0000_0033);
    run(1'b0, 8'd6, 8'h08, 16'h100, 2'd2, 0); @(negedge clk);
    chk("R8 ctl bit cleared again", ctl_reg, 32'hFFFF_F7FF);
  endtask

  task automatic t_limits;
    run(1'b1, 8'd0, 8'd0, 16'h1FFC, 2'd2, 32'h5555_AAAA); @(negedge clk);
    chk("R2 wide function accepts 0x1FFC", 32'(status), 0);
    chk("R1 wide address", 32'(lg_addr[base_n + 2]), 32'h1FFC);
    run(1'b0, 8'd0, 8'd0, 16'h2000, 2'd2, 0);
    chk("R2 bad register latency", 32'(lat), 1);
    chk("R2 bad register status", 32'(status), 1);
    @(negedge clk);
    chk("R2 no access on bad register", 32'(lg_n - base_n), 0);
    run(1'b0, 8'd1, 8'd0, 16'h1000, 2'd2, 0);
    chk("R2 standard limit status", 32'(status), 1);
    @(negedge clk);
    chk("R2 standard limit no access", 32'(lg_n - base_n), 0);
  endtask

  task automatic t_nodev;
    enable = 1'b0;
    run(1'b1, 8'd2, 8'd0, 16'h10, 2'd2, 32'h1);
    chk("R3 no device latency", 32'(lat), 1);
    chk("R3 no device status", 32'(status), 2);
    @(negedge clk);
    chk("R3 no access when disabled", 32'(lg_n - base_n), 0);
    enable = 1'b1;
  endtask

  task automatic t_recovery;
    run(1'b1, 8'd0, 8'h80, 16'h18, 2'd2, 32'hDEAD_BEEF); @(negedge clk);
    chk("R4 root write stays normal", 32'(lg_ctl[base_n]), 1);
    run(1'b0, 8'd0, 8'h80, 16'h1A, 2'd0, 0);
    chk("R9 recovery latency", 32'(lat), 7);
    chk("R6 byte extract", rdata, 32'h0000_00AD);
    @(negedge clk);
    chk("R5 three accesses", 32'(lg_n - base_n), 3);
    chk("R5 no ctl access", {29'b0, lg_ctl[base_n], lg_ctl[base_n + 1], lg_ctl[base_n + 2]}, 0);
    chk("R5 dummy addr", 32'(lg_addr[base_n]), 32'(ca(8'd0, 8'h80, 16'h10)));
    chk("R5 dummy zero write", {lg_wd[base_n][30:0], lg_we[base_n]}, 1);
    chk("R5 aligned read", {3'b0, lg_addr[base_n + 1], lg_we[base_n + 1]},
        {3'b0, ca(8'd0, 8'h80, 16'h18), 1'b0});
    chk("R5 write back", lg_wd[base_n + 2], 32'hDEAD_BEEF);
    chk("R5 write back addr", 32'(lg_addr[base_n + 2]), 32'(ca(8'd0, 8'h80, 16'h18)));
    chk("R5 full be", {24'b0, lg_be[base_n], lg_be[base_n + 2]}, 32'hFF);
    run(1'b0, 8'd0, 8'h80, 16'h1A, 2'd1, 0); @(negedge clk);
    chk("R6 high half", rdata, 32'h0000_DEAD);
    run(1'b0, 8'd0, 8'h80, 16'h18, 2'd1, 0); @(negedge clk);
    chk("R6 low half", rdata, 32'h0000_BEEF);
    run(1'b1, 8'd0, 8'h8B, 16'h174, 2'd2, 32'h0BAD_F00D); @(negedge clk);
    run(1'b0, 8'd0, 8'h8B, 16'h174, 2'd2, 0); @(negedge clk);
    chk("R4 slot 17 fn 3 upper range", 32'(lg_ctl[base_n]), 0);
    chk("R6 full dword", rdata, 32'h0BAD_F00D);
    run(1'b0, 8'd0, 8'h80, 16'h34, 2'd2, 0); @(negedge clk);
    chk("R4 range end excluded", 32'(lg_ctl[base_n]), 1);
    run(1'b0, 8'd0, 8'h84, 16'h18, 2'd2, 0); @(negedge clk);
    chk("R4 function 4 not root", 32'(lg_ctl[base_n]), 1);
    run(1'b0, 8'd1, 8'h80, 16'h18, 2'd2, 0); @(negedge clk);
    chk("R4 bus 1 not root", 32'(lg_ctl[base_n]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_bus5();
    t_limits();
    t_nodev();
    t_recovery();
    finish_run();
  end
endmodule